// File: doc/BRIEF.md
# Sequential Trigger Expression Engine

This block turns the per-cycle match bits of up to sixteen comparator units into a single trigger pulse. It hosts several independent expressions. Each expression is an ordered chain of up to four steps. A step forms a Boolean condition from a chosen subset of the match bits. Any selected bit may be inverted before the bits are reduced by AND, OR or XOR. A step must see its condition true a programmed number of times before the chain moves on. The cycles in which it is true need not be adjacent. A later step is not looked at until the earlier one has been satisfied.

Software writes step contents through a simple write port while the engine is running. It enables or disables each expression with a vector of enables, and it starts or stops evaluation with one-cycle arm and disarm pulses. When an expression finishes its last step, its hit bit pulses for one cycle and the expression restarts at its first step. The trigger output is the OR of all hit bits. A chain of one step with a count of one acts as a plain combinational trigger. Longer chains give sequential or mixed behaviour.

Top module: `trig_seq_engine`

## Requirements
- R1: With combine op 2'b00 a step condition is true when every selected bit of (match XOR invert mask) is 1. An empty select mask gives false. Op 2'b11 always gives false.
- R2: With op 2'b01 a step condition is the OR of the selected bits of (match XOR invert mask). With op 2'b10 it is the XOR of those bits.
- R3: A 1 in the invert mask flips that match bit before the combine, for every op.
- R4: An expression evaluates only its current step. Completing a step that is not the last one moves the expression to the next step. The last step is the one whose index equals the programmed last-step index, or step 3.
- R5: A step completes on the cycle in which its condition is true for the need-th time since the step became current. True cycles need not be consecutive. A need of 0 behaves as 1.
- R6: When an expression completes its last step in cycle t, its hit_o bit is 1 in cycle t+1 only, and the expression returns to step 0. trig_o is the OR of hit_o.
- R7: An expression whose expr_en_i bit is 0 gives no hit and has its step and occurrence progress cleared.
- R8: arm_i clears every expression's step and occurrence progress and starts evaluation from the next cycle. No hit comes from the arm cycle, even when arm_i and disarm_i are both 1.
- R9: disarm_i (without arm_i) stops evaluation from that same cycle. No hit occurs until the engine is armed again.
- R10: A config write stores the step's select, invert, op and need, and sets the last-step index of the addressed expression. It clears that expression's progress, and that expression gives no hit on the next cycle. Other expressions are unaffected.
- R11: After reset the engine is disarmed, all outputs are 0 and all config is cleared, so no step is satisfiable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| match_i | input | N_UNITS | Comparator unit match bits |
| expr_en_i | input | N_EXPR | Per-expression enable |
| arm_i | input | 1 | Clear progress and start evaluation |
| disarm_i | input | 1 | Stop evaluation |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_expr_i | input | EXPR_W | Expression addressed by the write |
| cfg_step_i | input | STEP_W | Step addressed by the write |
| cfg_last_i | input | STEP_W | Last-step index for the expression |
| cfg_sel_i | input | N_UNITS | Unit select mask |
| cfg_inv_i | input | N_UNITS | Unit invert mask |
| cfg_op_i | input | 2 | Combine op: 00 AND, 01 OR, 10 XOR, 11 never |
| cfg_need_i | input | CNT_W | Required occurrences |
| hit_o | output | N_EXPR | Per-expression completion pulse |
| trig_o | output | 1 | OR of all hit bits |

## Verification
Two things can land in one cycle. One is a step completion, the last one of an expression. The other is a control event: an arm pulse, or a config write addressed to that same expression. The bench sets up an expression so its final step is satisfied. It then drives the match pattern in the same cycle as arm_i, and again in the same cycle as a write to that expression. It expects no hit in either case and a normal hit one cycle later. A write to a different expression in the completing cycle must leave the hit intact. Random runs raise these same collisions often, and a bench model judges them cycle by cycle.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

   typedef enum logic [1:0] {
      OP_AND  = 2'b00,
      OP_OR   = 2'b01,
      OP_XOR  = 2'b10,
      OP_NONE = 2'b11
   } comb_op_e;

endpackage

// File: rtl/trig_step_eval.sv
module trig_step_eval
   import trig_seq_pkg::*;
#(
   parameter int N_UNITS = 16
) (
   input  logic [N_UNITS-1:0] match_i,
   input  logic [N_UNITS-1:0] sel_i,
   input  logic [N_UNITS-1:0] inv_i,
   input  comb_op_e           op_i,
   output logic               cond_o
);

   logic [N_UNITS-1:0] pol;
   logic [N_UNITS-1:0] picked;

   always_comb begin
      pol    = match_i ^ inv_i;
      picked = pol & sel_i;
      case (op_i)
         OP_AND:  cond_o = (|sel_i) && (&(pol | ~sel_i));
         OP_OR:   cond_o = |picked;
         OP_XOR:  cond_o = ^picked;
         default: cond_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/trig_seq_expr.sv
module trig_seq_expr
   import trig_seq_pkg::*;
#(
   parameter  int N_UNITS = 16,
   parameter  int N_STEPS = 4,
   parameter  int CNT_W   = 16,
   localparam int STEP_W  = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_UNITS-1:0] match_i,
   input  logic               en_i,
   input  logic               run_i,
   input  logic               clear_i,
   input  logic               wr_i,
   input  logic [STEP_W-1:0]  wr_step_i,
   input  logic [STEP_W-1:0]  wr_last_i,
   input  logic [N_UNITS-1:0] wr_sel_i,
   input  logic [N_UNITS-1:0] wr_inv_i,
   input  comb_op_e           wr_op_i,
   input  logic [CNT_W-1:0]   wr_need_i,
   output logic               hit_o
);

   typedef struct packed {
      logic [N_UNITS-1:0] sel;
      logic [N_UNITS-1:0] inv;
      comb_op_e           op;
      logic [CNT_W-1:0]   need;
   } step_cfg_t;

   step_cfg_t           cfg_q [N_STEPS];
   logic [STEP_W-1:0]   last_q;
   logic [STEP_W-1:0]   ptr_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                hit_q;
   logic [N_STEPS-1:0]  cond;
   logic                cond_cur;
   logic                done;
   logic                at_end;
   logic [CNT_W-1:0]    need_cur;

   // one evaluator per step; the pointer picks the live one
   for (genvar s = 0; s < N_STEPS; s++) begin : g_step
      trig_step_eval #(.N_UNITS(N_UNITS)) u_eval (
         .match_i (match_i),
         .sel_i   (cfg_q[s].sel),
         .inv_i   (cfg_q[s].inv),
         .op_i    (cfg_q[s].op),
         .cond_o  (cond[s])
      );
   end

   always_comb begin
      cond_cur = cond[ptr_q];
      need_cur = cfg_q[ptr_q].need;
      // need of zero compares as one
      done     = cond_cur &&
                 (({1'b0, cnt_q} + (CNT_W+1)'(1)) >= {1'b0, need_cur});
      at_end   = (ptr_q == last_q) || (ptr_q == STEP_W'(N_STEPS - 1));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < N_STEPS; s++) begin
            cfg_q[s] <= '{sel: '0, inv: '0, op: OP_AND, need: '0};
         end
         last_q <= '0;
      end else if (wr_i) begin
         cfg_q[wr_step_i] <= '{sel: wr_sel_i, inv: wr_inv_i,
                               op: wr_op_i, need: wr_need_i};
         last_q <= wr_last_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else begin
         hit_q <= 1'b0;
         if (clear_i || wr_i || !en_i) begin
            ptr_q <= '0;
            cnt_q <= '0;
         end else if (run_i && cond_cur) begin
            if (done) begin
               cnt_q <= '0;
               if (at_end) begin
                  ptr_q <= '0;
                  hit_q <= 1'b1;
               end else begin
                  ptr_q <= ptr_q + STEP_W'(1);
               end
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end

   assign hit_o = hit_q;

endmodule

// File: rtl/trig_seq_engine.sv
module trig_seq_engine
   import trig_seq_pkg::*;
#(
   parameter  int N_UNITS = 16,
   parameter  int N_EXPR  = 16,
   parameter  int N_STEPS = 4,
   parameter  int CNT_W   = 16,
   localparam int EXPR_W  = (N_EXPR > 1) ? $clog2(N_EXPR) : 1,
   localparam int STEP_W  = (N_STEPS > 1) ? $clog2(N_STEPS) : 1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [N_UNITS-1:0] match_i,
   input  logic [N_EXPR-1:0]  expr_en_i,
   input  logic               arm_i,
   input  logic               disarm_i,
   input  logic               cfg_we_i,
   input  logic [EXPR_W-1:0]  cfg_expr_i,
   input  logic [STEP_W-1:0]  cfg_step_i,
   input  logic [STEP_W-1:0]  cfg_last_i,
   input  logic [N_UNITS-1:0] cfg_sel_i,
   input  logic [N_UNITS-1:0] cfg_inv_i,
   input  logic [1:0]         cfg_op_i,
   input  logic [CNT_W-1:0]   cfg_need_i,
   output logic [N_EXPR-1:0]  hit_o,
   output logic               trig_o
);

   if (N_UNITS < 1 || N_UNITS > 256) begin : g_bad_units
      $error("trig_seq_engine: N_UNITS out of range");
   end
   if (N_EXPR < 1 || N_EXPR > 16) begin : g_bad_expr
      $error("trig_seq_engine: N_EXPR out of range");
   end
   if (N_STEPS < 1 || N_STEPS > 16) begin : g_bad_steps
      $error("trig_seq_engine: N_STEPS out of range");
   end
   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
      $error("trig_seq_engine: CNT_W out of range");
   end

   logic armed_q;
   logic run;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
      end else if (arm_i) begin
         armed_q <= 1'b1;
      end else if (disarm_i) begin
         armed_q <= 1'b0;
      end
   end

   // arm and disarm both suspend evaluation in their own cycle
   assign run = armed_q && !arm_i && !disarm_i;

   for (genvar e = 0; e < N_EXPR; e++) begin : g_expr
      trig_seq_expr #(
         .N_UNITS (N_UNITS),
         .N_STEPS (N_STEPS),
         .CNT_W   (CNT_W)
      ) u_expr (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .match_i   (match_i),
         .en_i      (expr_en_i[e]),
         .run_i     (run),
         .clear_i   (arm_i),
         .wr_i      (cfg_we_i && (cfg_expr_i == EXPR_W'(e))),
         .wr_step_i (cfg_step_i),
         .wr_last_i (cfg_last_i),
         .wr_sel_i  (cfg_sel_i),
         .wr_inv_i  (cfg_inv_i),
         .wr_op_i   (comb_op_e'(cfg_op_i)),
         .wr_need_i (cfg_need_i),
         .hit_o     (hit_o[e])
      );
   end

   assign trig_o = |hit_o;

endmodule

// File: rtl/trig_seq_engine_chk.sv
module trig_seq_engine_chk #(
   parameter int N_EXPR = 16,
   parameter int EXPR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [N_EXPR-1:0] expr_en_i,
   input logic              arm_i,
   input logic              disarm_i,
   input logic              cfg_we_i,
   input logic [EXPR_W-1:0] cfg_expr_i,
   input logic [N_EXPR-1:0] hit_o,
   input logic              trig_o,
   input logic              armed_q
);

   // R8: nothing fires out of an arm cycle
   p_arm_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      arm_i |=> (trig_o == 1'b0));

   // R8: a trigger needs the engine armed in the evaluating cycle
   p_trig_armed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      trig_o |-> $past(armed_q));

   // R9: while disarmed nothing fires
   p_disarmed_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_q |-> (trig_o == 1'b0));

   // R9: disarm without arm drops the armed state
   p_disarm_stops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (disarm_i && !arm_i) |=> !armed_q);

   // R7: a disabled expression gives no hit
   p_disabled_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit_o & ~$past(expr_en_i)) == '0);

   // R10: a written expression is silent on the following cycle
   p_cfg_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_we_i |=> (hit_o[$past(cfg_expr_i)] == 1'b0));

endmodule

bind trig_seq_engine trig_seq_engine_chk #(
   .N_EXPR (N_EXPR),
   .EXPR_W (EXPR_W)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .expr_en_i  (expr_en_i),
   .arm_i      (arm_i),
   .disarm_i   (disarm_i),
   .cfg_we_i   (cfg_we_i),
   .cfg_expr_i (cfg_expr_i),
   .hit_o      (hit_o),
   .trig_o     (trig_o),
   .armed_q    (armed_q)
);

// File: tb/trig_seq_engine_tb.sv
module trig_seq_engine_tb;

   localparam int NU = 16;
   localparam int NE = 16;
   localparam int NS = 4;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NU-1:0] match;
   logic [NE-1:0] en;
   logic          arm, disarm, cfg_we;
   logic [3:0]    cfg_expr;
   logic [1:0]    cfg_step, cfg_last, cfg_op;
   logic [NU-1:0] cfg_sel, cfg_inv;
   logic [CW-1:0] cfg_need;
   logic [NE-1:0] hit;
   logic          trig;

   always #10 clk = ~clk;

   trig_seq_engine u_dut (
      .clk_i (clk), .rst_ni (rst_n), .match_i (match), .expr_en_i (en),
      .arm_i (arm), .disarm_i (disarm), .cfg_we_i (cfg_we),
      .cfg_expr_i (cfg_expr), .cfg_step_i (cfg_step), .cfg_last_i (cfg_last),
      .cfg_sel_i (cfg_sel), .cfg_inv_i (cfg_inv), .cfg_op_i (cfg_op),
      .cfg_need_i (cfg_need), .hit_o (hit), .trig_o (trig)
   );

   // bench model
   logic [NU-1:0] m_sel  [NE][NS];
   logic [NU-1:0] m_inv  [NE][NS];
   logic [1:0]    m_op   [NE][NS];
   logic [CW-1:0] m_need [NE][NS];
   int            m_last [NE];
   int            m_ptr  [NE];
   int            m_cnt  [NE];
   bit            m_armed;
   logic [NE-1:0] exp_hit;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   function automatic bit f_cond(logic [NU-1:0] m, logic [NU-1:0] s,
                                 logic [NU-1:0] v, logic [1:0] op);
      logic [NU-1:0] pol, pk;
      pol = m ^ v;
      pk  = pol & s;
      case (op)
         2'b00:   return (s != '0) && ((pol | ~s) == '1);
         2'b01:   return pk != '0;
         2'b10:   return ^pk;
         default: return 1'b0;
      endcase
   endfunction

   task automatic model_reset();
      for (int e = 0; e < NE; e++) begin
         for (int s = 0; s < NS; s++) begin
            m_sel[e][s] = '0; m_inv[e][s] = '0; m_op[e][s] = '0; m_need[e][s] = '0;
         end
         m_last[e] = 0; m_ptr[e] = 0; m_cnt[e] = 0;
      end
      m_armed = 0;
      exp_hit = '0;
   endtask

   task automatic model_step();
      bit run;
      bit wr;
      int nd;
      run = m_armed && !arm && !disarm;
      for (int e = 0; e < NE; e++) begin
         wr = cfg_we && (int'(cfg_expr) == e);
         exp_hit[e] = 1'b0;
         if (wr) begin
            m_sel[e][cfg_step]  = cfg_sel;
            m_inv[e][cfg_step]  = cfg_inv;
            m_op[e][cfg_step]   = cfg_op;
            m_need[e][cfg_step] = cfg_need;
            m_last[e] = int'(cfg_last);
         end
         if (arm || wr || !en[e]) begin
            m_ptr[e] = 0; m_cnt[e] = 0;
         end else if (run && f_cond(match, m_sel[e][m_ptr[e]], m_inv[e][m_ptr[e]],
                                    m_op[e][m_ptr[e]])) begin
            nd = int'(m_need[e][m_ptr[e]]);
            if (m_cnt[e] + 1 >= nd) begin
               m_cnt[e] = 0;
               if (m_ptr[e] == m_last[e] || m_ptr[e] == NS - 1) begin
                  m_ptr[e] = 0;
                  exp_hit[e] = 1'b1;
               end else begin
                  m_ptr[e] = m_ptr[e] + 1;
               end
            end else begin
               m_cnt[e] = m_cnt[e] + 1;
            end
         end
      end
      if (arm) m_armed = 1;
      else if (disarm) m_armed = 0;
   endtask

   task automatic check(string tag);
      total++;
      if (hit !== exp_hit || trig !== (|exp_hit)) begin
         bad++;
         $display("FAIL %s: hit=%h trig=%b expected hit=%h trig=%b",
                  tag, hit, trig, exp_hit, |exp_hit);
      end
   endtask

   task automatic tick(string tag);
      model_step();
      @(posedge clk);
      #2;
      check(tag);
      arm = 0; disarm = 0; cfg_we = 0;
   endtask

   task automatic cfgw(int e, int s, int last, logic [NU-1:0] sel,
                       logic [NU-1:0] inv, logic [1:0] op, logic [CW-1:0] need,
                       string tag);
      cfg_we = 1; cfg_expr = 4'(e); cfg_step = 2'(s); cfg_last = 2'(last);
      cfg_sel = sel; cfg_inv = inv; cfg_op = op; cfg_need = need;
      tick(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog R6: run not finished, expected end before 200000 cycles");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 0; match = '0; en = '0; arm = 0; disarm = 0; cfg_we = 0;
      cfg_expr = '0; cfg_step = '0; cfg_last = '0; cfg_sel = '0; cfg_inv = '0;
      cfg_op = '0; cfg_need = '0;
      model_reset();
      repeat (3) @(posedge clk);
      #2;
      check("R11 reset outputs");
      rst_n = 1;

      // R11: cleared config never satisfies a step
      en = '1; match = '1; arm = 1;
      tick("R11 arm after reset");
      repeat (3) tick("R11 cleared config");

      // R1 AND
      en = 16'h0001;
      cfgw(0, 0, 0, 16'h0003, 16'h0000, 2'b00, 16'd1, "R1 cfg");
      match = 16'h0001; tick("R1 AND partial");
      match = 16'h0003; tick("R1 AND full");
      match = 16'h0000; tick("R6 idle after hit");
      cfgw(0, 0, 0, 16'h0000, 16'h0000, 2'b00, 16'd1, "R1 empty sel cfg");
      match = '1; tick("R1 empty sel false");
      cfgw(0, 0, 0, 16'hFFFF, 16'h0000, 2'b11, 16'd1, "R1 op11 cfg");
      tick("R1 op 11 false");

      // R3 inversion
      cfgw(0, 0, 0, 16'h0003, 16'h0002, 2'b00, 16'd1, "R3 cfg");
      match = 16'h0001; tick("R3 inverted AND true");
      match = 16'h0003; tick("R3 inverted AND false");

      // R2 OR and XOR
      cfgw(0, 0, 0, 16'h00F0, 16'h0000, 2'b01, 16'd1, "R2 or cfg");
      match = 16'h0010; tick("R2 OR true");
      match = 16'h0F0F; tick("R2 OR false");
      cfgw(0, 0, 0, 16'h000F, 16'h0000, 2'b10, 16'd1, "R2 xor cfg");
      match = 16'h0003; tick("R2 XOR even");
      match = 16'h0007; tick("R2 XOR odd");

      // R4 THEN ordering
      cfgw(0, 0, 1, 16'h0001, 16'h0000, 2'b01, 16'd1, "R4 cfg0");
      cfgw(0, 1, 1, 16'h0002, 16'h0000, 2'b01, 16'd1, "R4 cfg1");
      match = 16'h0002; tick("R4 later step ignored first");
      match = 16'h0001; tick("R4 step0 done");
      match = 16'h0001; tick("R4 step1 not met");
      match = 16'h0002; tick("R4 chain complete");
      match = 16'h0003; tick("R4 restart step0");
      match = 16'h0003; tick("R4 second chain");

      // R5 occurrence count
      cfgw(0, 0, 0, 16'h0001, 16'h0000, 2'b01, 16'd3, "R5 cfg");
      match = 16'h0001; tick("R5 occ1");
      match = 16'h0000; tick("R5 gap");
      match = 16'h0001; tick("R5 occ2");
      match = 16'h0000; tick("R5 gap");
      match = 16'h0001; tick("R5 occ3 hits");
      cfgw(0, 0, 0, 16'h0001, 16'h0000, 2'b01, 16'd0, "R5 need0 cfg");
      match = 16'h0001; tick("R5 need0 as one");
      tick("R5 need0 again");

      // R7 enable
      cfgw(0, 0, 0, 16'h0001, 16'h0000, 2'b01, 16'd2, "R7 cfg");
      match = 16'h0001; tick("R7 occ1");
      en = '0; tick("R7 disabled clears");
      en = 16'h0001; tick("R7 count restarted");
      tick("R7 hit after restart");

      // R8 arm colliding with completion
      cfgw(0, 0, 0, 16'h0001, 16'h0000, 2'b01, 16'd1, "R8 cfg");
      arm = 1; tick("R8 arm beats completion");
      tick("R8 hit after arm");
      arm = 1; disarm = 1; tick("R8 arm beats disarm");
      tick("R8 still armed");

      // R9 disarm
      disarm = 1; tick("R9 disarm cycle");
      tick("R9 disarmed");
      tick("R9 disarmed");
      arm = 1; tick("R9 rearm");
      tick("R9 rearmed hit");

      // R10 write collisions
      cfgw(0, 0, 0, 16'h0001, 16'h0000, 2'b01, 16'd1, "R10 write own expr");
      en = 16'h0003;
      cfgw(1, 0, 0, 16'h0002, 16'h0000, 2'b01, 16'd1, "R10 write other expr");
      match = 16'h0003; tick("R6 two expressions together");
      match = 16'h0002; tick("R6 one expression");

      // constrained random
      en = '1; arm = 1; tick("R8 random arm");
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = int'($urandom % 100);
         match = 16'($urandom | $urandom);
         if (r < 2) arm = 1;
         else if (r < 4) disarm = 1;
         else if (r < 12) begin
            cfg_we = 1;
            cfg_expr = 4'($urandom);
            cfg_step = 2'($urandom);
            cfg_last = 2'($urandom);
            cfg_sel = 16'($urandom & $urandom);
            cfg_inv = 16'($urandom & $urandom & $urandom);
            cfg_op = 2'($urandom);
            cfg_need = 16'($urandom % 4);
         end
         if ($urandom % 40 == 0) en[$urandom % NE] = ~en[$urandom % NE];
         tick("R6 random");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule